// File: doc/BRIEF.md
# Audio PCM-to-PWM Generator

The block turns a mono stream of PCM samples into a single-bit pulse-width output. An RC filter and a speaker can sit directly on that output, so no DAC is needed. Each incoming sample is first conditioned. An 8-bit sample is placed in the upper byte. Offset-binary samples are converted to two's complement. The value is then attenuated by an arithmetic right shift and biased back to unsigned. The block then splits the 16-bit value into a coarse part and a fine part. The coarse part sets the high time of a carrier whose length is a power of two. When fine mode is on, the fine part spreads one extra count of high time over a run of consecutive carrier periods, which gives resolution below one carrier count.

Samples enter through a one-entry holding register with a valid/ready handshake. The active sample is replaced only at a carrier boundary, once every configured number of carrier periods. A one-cycle request pulse asks a DMA engine for the next sample at each of those boundaries. If no sample is waiting at a boundary, the old sample plays again and an underrun flag is raised. Two compare-match outputs mark the start of each carrier period and the end of its high phase.

Top module: `pcm_pwm_gen`

## Requirements
- R1: After reset is released, pwmOut is 0 for the first carrier period, sampleReady is 1, underrun, dmaReq and dutyIrq are 0, and periodIrq is 1. The active sample resets to the midpoint 0x8000.
- R2: cfgMode selects the coarse width C. Code 0 gives C=10, code 1 gives C=9, and codes 2 and 3 give C=8. The fine width is F=16-C. Each carrier period lasts exactly 2^C cycles. With fine mode off, pwmOut is high for the first (sample >> F) cycles of the period.
- R3: With cfgFineEn=1, a carrier period gets one extra high cycle when its dither index is below the low F bits of the sample. The dither index is the number of carrier periods since reset, modulo 2^F; the first period after reset has index 0. With cfgFineEn=0 the low bits have no effect. A coarse value of all ones plus the extra count keeps pwmOut high for the whole period.
- R4: With cfgPcm8=1, sampleData[7:0] becomes bits 15:8 of the sample, the lower byte is zero and sampleData[15:8] is ignored. With cfgPcm8=0, all 16 bits are used.
- R5: With cfgUnsigned=1, the input is offset binary and its bit 15 is inverted to form the signed value. With cfgUnsigned=0, the input is two's complement. The modulated value is the signed result with bit 15 inverted.
- R6: The signed sample is arithmetically shifted right by cfgVolume (0 to 15) before it is biased to unsigned.
- R7: The high time is fixed for the whole carrier period. A new sample or new duty takes effect only at the start of the next period, and within a period pwmOut never rises after it has fallen.
- R8: sampleReady is 1 exactly when the holding register is empty. A sample is taken on a cycle with sampleValid and sampleReady both 1, and sampleReady is 0 on the following cycle.
- R9: The holding sample becomes active every N carrier periods, where N is cfgCarriersPerSample and a value of 0 acts as 1. dmaReq is high for the single cycle at the end of each such N-th period. The first pulse comes 256*N-1 cycles after reset release in mode 2.
- R10: If the holding register is empty at a sample boundary, the active sample is repeated and underrun goes to 1. underrun stays 1 until a boundary at which a sample is loaded.
- R11: periodIrq is 1 in the first cycle of every carrier period. dutyIrq is 1 in the first low cycle of a period whose high time is between 1 and 2^C-1, and it is never 1 in other periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgMode | input | 2 | Coarse/fine split code |
| cfgPcm8 | input | 1 | 8-bit sample format |
| cfgUnsigned | input | 1 | Offset-binary input format |
| cfgFineEn | input | 1 | Fine dithering enable |
| cfgVolume | input | 4 | Attenuation shift |
| cfgCarriersPerSample | input | RATE_W | Carrier periods per sample |
| sampleData | input | 16 | PCM sample |
| sampleValid | input | 1 | Sample offered |
| sampleReady | output | 1 | Holding register empty |
| dmaReq | output | 1 | Next-sample request pulse |
| underrun | output | 1 | Sample repeated for lack of input |
| pwmOut | output | 1 | Modulated output |
| periodIrq | output | 1 | Carrier period start match |
| dutyIrq | output | 1 | High-phase end match |

## Verification
Sample streams are played through every split code. Full-scale, zero, midpoint and arbitrary words are used, so a wrong coarse shift or a wrong carrier length shows up in the measured high count of each period. The signed and offset-binary formats, nonzero volume shifts and the 8-bit format with garbage in the upper byte are run separately, so a missing sign inversion, a logical instead of arithmetic shift or a wrong byte lane each gives a distinct count. Fine values are played with a known dither index across consecutive periods, which tells an off-by-one in the dither comparison apart from a missing extra count. A multi-period sample rate and a starved stream expose request timing and the repeat-on-underrun behaviour.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int HALF_W     = SAMPLE_W / 2;
  localparam int MAX_COARSE = 10;
  localparam int MAX_FINE   = SAMPLE_W - 8;
  localparam int CNT_W      = MAX_COARSE;
  localparam int DUTY_W     = MAX_COARSE + 1;

  typedef struct packed {
    logic acceptIn;
    logic carrierEnd;
    logic sampleLoad;
  } strobe_t;

  function automatic int coarseBits(input logic [1:0] mode);
    case (mode)
      2'd0:    return 10;
      2'd1:    return 9;
      default: return 8;
    endcase
  endfunction

  function automatic int fineBits(input logic [1:0] mode);
    return SAMPLE_W - coarseBits(mode);
  endfunction
endpackage

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
  import pcm_pwm_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfgMode,
  input  logic [RATE_W-1:0]   cfgCarriersPerSample,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                dmaReq,
  output logic                underrun,
  output logic                periodIrq,
  output logic [CNT_W-1:0]    carrierCnt,
  output logic [MAX_FINE-1:0] ditherNext,
  output strobe_t             strobe
);
  logic [CNT_W-1:0]    lastCnt;
  logic [RATE_W-1:0]   rateCnt;
  logic [RATE_W-1:0]   rateLast;
  logic [MAX_FINE-1:0] ditherIdx;
  logic                holdFull;
  logic                carrierEnd;
  logic                sampleEdge;

  always_comb begin
    lastCnt           = CNT_W'((1 << coarseBits(cfgMode)) - 1);
    rateLast          = (cfgCarriersPerSample == '0) ? '0 : cfgCarriersPerSample - 1'b1;
    carrierEnd        = carrierCnt >= lastCnt;
    sampleEdge        = carrierEnd && (rateCnt >= rateLast);
    ditherNext        = ditherIdx + 1'b1;
    strobe.acceptIn   = sampleValid && !holdFull;
    strobe.carrierEnd = carrierEnd;
    strobe.sampleLoad = sampleEdge && holdFull;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carrierCnt <= '0;
      ditherIdx  <= '0;
      rateCnt    <= '0;
      holdFull   <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      carrierCnt <= carrierEnd ? '0 : carrierCnt + 1'b1;
      if (carrierEnd) begin
        ditherIdx <= ditherNext;
        rateCnt   <= sampleEdge ? '0 : rateCnt + 1'b1;
      end
      if (strobe.acceptIn)        holdFull <= 1'b1;
      else if (strobe.sampleLoad) holdFull <= 1'b0;
      if (sampleEdge) underrun <= !holdFull;
    end
  end

  assign sampleReady = !holdFull;
  assign dmaReq      = sampleEdge;
  assign periodIrq   = (carrierCnt == '0);

  // R8
  accept_full_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid && sampleReady |=> !sampleReady);

  // R9
  dma_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    dmaReq |=> periodIrq);

  // R10
  underrun_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(dmaReq));

  // R10
  underrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    underrun && !dmaReq |=> underrun);
endmodule

// File: rtl/pcm_pwm_datapath.sv
module pcm_pwm_datapath
  import pcm_pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfgMode,
  input  logic                cfgPcm8,
  input  logic                cfgUnsigned,
  input  logic                cfgFineEn,
  input  logic [3:0]          cfgVolume,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  strobe_t             strobe,
  input  logic [CNT_W-1:0]    carrierCnt,
  input  logic [MAX_FINE-1:0] ditherNext,
  output logic                pwmOut,
  output logic                dutyIrq
);
  localparam logic [SAMPLE_W-1:0] SIGN_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] justified;
  logic [SAMPLE_W-1:0] signedForm;
  logic [SAMPLE_W-1:0] scaled;
  logic [SAMPLE_W-1:0] condSample;
  logic [SAMPLE_W-1:0] holdReg;
  logic [SAMPLE_W-1:0] actReg;
  logic [SAMPLE_W-1:0] actNext;
  logic [SAMPLE_W-1:0] fineMask;
  logic [SAMPLE_W-1:0] fineVal;
  logic [SAMPLE_W-1:0] ditherLow;
  logic [DUTY_W-1:0]   dutyReg;
  logic [DUTY_W-1:0]   dutyCalc;
  logic [DUTY_W-1:0]   cntWide;
  logic                extra;
  int                  fb;

  always_comb begin
    justified  = cfgPcm8 ? {sampleData[HALF_W-1:0], {HALF_W{1'b0}}} : sampleData;
    signedForm = cfgUnsigned ? (justified ^ SIGN_BIT) : justified;
    scaled     = SAMPLE_W'($signed(signedForm) >>> cfgVolume);
    condSample = scaled ^ SIGN_BIT;
    actNext    = strobe.sampleLoad ? holdReg : actReg;
    fb         = fineBits(cfgMode);
    fineMask   = SAMPLE_W'((1 << fb) - 1);
    fineVal    = actNext & fineMask;
    ditherLow  = {{(SAMPLE_W-MAX_FINE){1'b0}}, ditherNext} & fineMask;
    extra      = cfgFineEn && (ditherLow < fineVal);
    dutyCalc   = DUTY_W'(actNext >> fb) + DUTY_W'(extra);
    cntWide    = {1'b0, carrierCnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
      actReg  <= SIGN_BIT;
      dutyReg <= '0;
    end else begin
      if (strobe.acceptIn) holdReg <= condSample;
      if (strobe.carrierEnd) begin
        actReg  <= actNext;
        dutyReg <= dutyCalc;
      end
    end
  end

  assign pwmOut  = cntWide < dutyReg;
  assign dutyIrq = (dutyReg != '0) && (cntWide == dutyReg);

  // R7
  duty_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.carrierEnd |=> $stable(dutyReg));

  // R11
  duty_irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    dutyIrq |-> !pwmOut && $past(pwmOut));
endmodule

// File: rtl/pcm_pwm_gen.sv
module pcm_pwm_gen
  import pcm_pwm_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfgMode,
  input  logic              cfgPcm8,
  input  logic              cfgUnsigned,
  input  logic              cfgFineEn,
  input  logic [3:0]        cfgVolume,
  input  logic [RATE_W-1:0] cfgCarriersPerSample,
  input  logic [15:0]       sampleData,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic              dmaReq,
  output logic              underrun,
  output logic              pwmOut,
  output logic              periodIrq,
  output logic              dutyIrq
);
  strobe_t             strobe;
  logic [CNT_W-1:0]    carrierCnt;
  logic [MAX_FINE-1:0] ditherNext;

  pcm_pwm_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk                  (clk),
    .rst                  (rst),
    .cfgMode              (cfgMode),
    .cfgCarriersPerSample (cfgCarriersPerSample),
    .sampleValid          (sampleValid),
    .sampleReady          (sampleReady),
    .dmaReq               (dmaReq),
    .underrun             (underrun),
    .periodIrq            (periodIrq),
    .carrierCnt           (carrierCnt),
    .ditherNext           (ditherNext),
    .strobe               (strobe)
  );

  pcm_pwm_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .cfgMode     (cfgMode),
    .cfgPcm8     (cfgPcm8),
    .cfgUnsigned (cfgUnsigned),
    .cfgFineEn   (cfgFineEn),
    .cfgVolume   (cfgVolume),
    .sampleData  (sampleData),
    .strobe      (strobe),
    .carrierCnt  (carrierCnt),
    .ditherNext  (ditherNext),
    .pwmOut      (pwmOut),
    .dutyIrq     (dutyIrq)
  );
endmodule

// File: tb/pcm_pwm_gen_bench.sv
module pcm_pwm_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfgMode = 2'd2;
  logic        cfgPcm8 = 1'b0;
  logic        cfgUnsigned = 1'b1;
  logic        cfgFineEn = 1'b0;
  logic [3:0]  cfgVolume = 4'd0;
  logic [7:0]  cfgCarriersPerSample = 8'd1;
  logic [15:0] sampleData = 16'h0;
  logic        sampleValid = 1'b0;
  logic        sampleReady, dmaReq, underrun, pwmOut, periodIrq, dutyIrq;

  pcm_pwm_gen u_pcm_pwm_gen (
    .clk(clk), .rst(rst), .cfgMode(cfgMode), .cfgPcm8(cfgPcm8),
    .cfgUnsigned(cfgUnsigned), .cfgFineEn(cfgFineEn), .cfgVolume(cfgVolume),
    .cfgCarriersPerSample(cfgCarriersPerSample), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .dmaReq(dmaReq),
    .underrun(underrun), .pwmOut(pwmOut), .periodIrq(periodIrq), .dutyIrq(dutyIrq)
  );

  always #2.5ns clk = ~clk;

  int checks = 0;
  int fails = 0;
  string secTag = "R2";
  logic [15:0] q[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int cBits();
    return (cfgMode == 2'd0) ? 10 : (cfgMode == 2'd1) ? 9 : 8;
  endfunction

  function automatic logic [15:0] cond(input logic [15:0] d);
    logic [15:0] raw, s, sh;
    raw = cfgPcm8 ? {d[7:0], 8'h00} : d;
    s   = cfgUnsigned ? (raw ^ 16'h8000) : raw;
    sh  = 16'($signed(s) >>> cfgVolume);
    return sh ^ 16'h8000;
  endfunction

  function automatic int expDuty(input logic [15:0] u, input int k);
    int f, coarse, fine, ext;
    f = 16 - cBits();
    coarse = int'(u) >> f;
    fine = int'(u) & ((1 << f) - 1);
    ext = (cfgFineEn && ((k % (1 << f)) < fine)) ? 1 : 0;
    return coarse + ext;
  endfunction

  // monitor: measures each carrier period and compares with the queue
  int perK, highs, len, irqPos;
  bit have, fell, rose;
  logic [15:0] expU;

  task automatic finishPeriod();
    int d, ex;
    d = expDuty(expU, perK);
    chk(highs == d, secTag, $sformatf("high cycles period %0d", perK), highs, d);
    chk(len == (1 << cBits()), "R2", "carrier length", len, 1 << cBits());
    chk(!rose, "R7", "single high run", int'(rose), 0);
    ex = (d > 0 && d < (1 << cBits())) ? d : -1;
    chk(irqPos == ex, "R11", "dutyIrq position", irqPos, ex);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      perK = -1;
      have = 0;
    end else begin
      if (periodIrq) begin
        if (have) finishPeriod();
        perK++;
        highs = 0; len = 0; irqPos = -1; fell = 0; rose = 0; have = 0;
        if (perK >= 1 && q.size() > 0) begin
          expU = q.pop_front();
          have = 1;
        end
      end
      if (have) begin
        if (pwmOut) begin
          highs++;
          if (fell) rose = 1;
        end else fell = 1;
        if (dutyIrq && irqPos < 0) irqPos = len;
        len++;
      end
    end
  end

  int cyc;
  int dmaAt[8];
  int dmaN;
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
      dmaN = 0;
    end else begin
      if (dmaReq && dmaN < 8) begin
        dmaAt[dmaN] = cyc;
        dmaN++;
      end
      cyc++;
    end
  end

  task automatic section(input logic [1:0] m, input bit p8, input bit uns, input bit fe,
                         input logic [3:0] vol, input logic [7:0] rate, input string tag);
    @(posedge clk); #1ns;
    rst = 1'b1;
    cfgMode = m; cfgPcm8 = p8; cfgUnsigned = uns; cfgFineEn = fe;
    cfgVolume = vol; cfgCarriersPerSample = rate; sampleValid = 1'b0;
    secTag = tag;
    q.delete();
    repeat (3) @(posedge clk);
    #1ns;
    rst = 1'b0;
    @(negedge clk);
    chk(pwmOut == 1'b0, "R1", "pwmOut after reset", int'(pwmOut), 0);
    chk(sampleReady == 1'b1, "R1", "sampleReady after reset", int'(sampleReady), 1);
    chk(underrun == 1'b0 && dmaReq == 1'b0 && dutyIrq == 1'b0, "R1", "flags after reset",
        int'({underrun, dmaReq, dutyIrq}), 0);
    chk(periodIrq == 1'b1, "R1", "periodIrq after reset", int'(periodIrq), 1);
  endtask

  task automatic feed(input logic [15:0] d);
    q.push_back(cond(d));
    do begin
      @(posedge clk); #1ns;
    end while (!sampleReady);
    sampleData = d;
    sampleValid = 1'b1;
    @(posedge clk); #1ns;
    sampleValid = 1'b0;
    sampleData = 16'hDEAD;
    chk(sampleReady == 1'b0, "R8", "ready after accept", int'(sampleReady), 0);
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      @(posedge clk); #1ns;
    end
    repeat (2 * (1 << cBits()) + 4) @(posedge clk);
    #1ns;
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) begin
      @(posedge clk); #1ns;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    // R2: plain coarse duty in 8+8 split, rate code 0 acting as one carrier per sample
    section(2'd2, 1'b0, 1'b1, 1'b0, 4'd0, 8'd0, "R2");
    feed(16'h0000); feed(16'hFFFF); feed(16'h8000); feed(16'h1234); feed(16'h00FF);
    drain();
    // R2: 9+7 split
    section(2'd1, 1'b0, 1'b1, 1'b0, 4'd0, 8'd1, "R2");
    feed(16'hFFFF); feed(16'h0080); feed(16'h5A5A);
    drain();
    // R5: two's complement input, 10+6 split
    section(2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd1, "R5");
    feed(16'h7FFF); feed(16'h8000); feed(16'h0000); feed(16'hC000);
    drain();
    // R6: volume shift on signed samples
    section(2'd1, 1'b0, 1'b0, 1'b0, 4'd3, 8'd1, "R6");
    feed(16'h8000); feed(16'h7FFF); feed(16'hC000); feed(16'h1000);
    drain();
    section(2'd2, 1'b0, 1'b1, 1'b0, 4'd15, 8'd1, "R6");
    feed(16'h0000); feed(16'hFFFF);
    drain();
    // R4: 8-bit samples, upper byte ignored
    section(2'd2, 1'b1, 1'b1, 1'b0, 4'd0, 8'd1, "R4");
    feed(16'hAB10); feed(16'h00FF); feed(16'h5580);
    drain();
    section(2'd1, 1'b1, 1'b0, 1'b0, 4'd1, 8'd1, "R4");
    feed(16'h0040); feed(16'hFF80);
    drain();
    // R3: fine dithering in 8+8 split, dither index equals period number
    section(2'd2, 1'b0, 1'b1, 1'b1, 4'd0, 8'd1, "R3");
    for (int i = 0; i < 5; i++) feed(16'h4003);
    feed(16'hFFFF); feed(16'hFFFF); feed(16'h0001);
    drain();
    // R3: fine dithering in 10+6 split
    section(2'd0, 1'b0, 1'b1, 1'b1, 4'd0, 8'd1, "R3");
    for (int i = 0; i < 7; i++) feed(16'h2005);
    drain();
    // R9: three carrier periods per sample
    section(2'd2, 1'b0, 1'b1, 1'b0, 4'd0, 8'd3, "R9");
    q.push_back(16'h8000); q.push_back(16'h8000);
    feed(16'h3000);
    q.push_back(16'h3000); q.push_back(16'h3000);
    feed(16'hC000);
    drain();
    chk(dmaN >= 2, "R9", "dmaReq pulse count", dmaN, 2);
    chk(dmaAt[0] == 767, "R9", "first dmaReq cycle", dmaAt[0], 767);
    chk(dmaAt[1] - dmaAt[0] == 768, "R9", "dmaReq spacing", dmaAt[1] - dmaAt[0], 768);
    // R10: starved stream repeats the last sample
    section(2'd2, 1'b0, 1'b1, 1'b0, 4'd0, 8'd1, "R10");
    feed(16'h6000);
    q.push_back(cond(16'h6000));
    waitCyc(600);
    chk(underrun == 1'b1, "R10", "underrun after starved boundary", int'(underrun), 1);
    chk(sampleReady == 1'b1, "R10", "holding empty while starved", int'(sampleReady), 1);
    feed(16'h2000);
    waitCyc(900);
    chk(underrun == 1'b0, "R10", "underrun cleared after load", int'(underrun), 0);
    drain();
    summary();
    $finish;
  end
endmodule